// File: doc/BRIEF.md
# Four-Channel Square-Wave Tone Generator

This block generates four square waves, numbered channel 0 to channel 3, and mixes them into one unsigned audio sample. Software programs it through a small port-write interface. Each channel has a 16-bit period word and a 4-bit loudness. A shared tick-enable input sets the rate at which every channel's counter runs.

Each channel holds a down-counter. A tick with the counter at zero loads the period word into the counter. Later ticks count it down. The channel flips its output level on the tick that takes the counter from one to zero. One half-period is therefore the period word plus one tick. A period word of zero parks the channel at the high level, so that channel can be silenced or held.

The mixed sample is the sum of the loudness values of every channel whose level is high.

Top module: `tone_mixer4`

## Requirements
- R1: While `rst_n` is low, all period words, loudness values and counters clear to 0 and every channel level is high. On the first cycle after reset, `level` reads 4'hF and `sample` reads 0.
- R2: A write to port 4, 5, 6 or 7 stores all 16 data bits as the period word of channel 0, 1, 2 or 3. Channel k drives `level[k]`.
- R3: A write to port 8 sets channel 0's loudness from data[7:4] and channel 1's from data[3:0]. A write to port 9 sets channel 2's loudness from data[7:4] and channel 3's from data[3:0]. Data bits [15:8] of these writes are ignored.
- R4: A write to any other port number changes no period word, no loudness and no output.
- R5: In a cycle with `tick` low, no counter and no level changes on the next clock.
- R6: On a tick with a nonzero period word and the counter at 0, the counter loads the period word.
- R7: A channel's level inverts on the tick that steps its counter from 1 to 0. With a fixed nonzero period word N, consecutive inversions are N+1 ticks apart, however the ticks are spaced in time.
- R8: On a tick with a zero period word, the channel's level is forced high and its counter is held at 0. The level does not invert while the period word stays zero.
- R9: `sample` equals the sum of the loudness values of the channels whose level is high. It is 6 bits wide and changes in the same cycle as `level`.
- R10: A port write takes effect on the clock that samples it. A tick in that same cycle still uses the previous period word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-cycle enable that advances all channel counters |
| wr_en | input | 1 | Port write strobe |
| wr_port | input | 4 | Port number of the write |
| wr_data | input | 16 | Write data |
| level | output | 4 | Per-channel square-wave level, 1 = high (positive) |
| sample | output | 6 | Mixed unsigned audio sample |

## Verification
The bound checker watches, on every cycle, these per-cycle rules:
- the state is frozen while `tick` is low;
- a counter reloads its period word when it steps from zero;
- a level inverts only as the counter lands on zero;
- a channel is parked high on a tick with a zero period word;
- the mix is correct when all levels are high or all are low.

The decode of each port number, the ignored upper byte of the loudness writes, and the timing of a write in the same cycle as a tick can be shown only by the bench's scenarios, as can the exact N+1 spacing between inversions under dense and sparse ticks. The bench's behavioural model checks every clock against them.

// File: rtl/tone_pkg.sv
// Shared sizing for the four-channel tone generator.
// Assumes the period width does not exceed the write data width.
package tone_pkg;
    localparam int TONE_CH_N    = 4;
    localparam int TONE_CNT_W   = 16;
    localparam int TONE_VOL_W   = 4;
    localparam int TONE_PORT_W  = 4;
    localparam int TONE_DATA_W  = 16;
    localparam int TONE_FREQ_P0 = 4;   // port of channel 0 period word
    localparam int TONE_VOL_P0  = 8;   // port holding channels 0 and 1 loudness
endpackage

// File: rtl/tone_regs.sv
// Port-write decode and storage for period words and loudness values.
// Channel i takes its period from port FREQ_BASE+i. Loudness pairs share
// port VOL_BASE+i/2: the even channel sits in the upper nibble of the low
// byte, the odd one in the lower nibble. Writes land on the sampling clock.
module tone_regs #(
    parameter int CH_N      = 4,
    parameter int CNT_W     = 16,
    parameter int VOL_W     = 4,
    parameter int PORT_W    = 4,
    parameter int DATA_W    = 16,
    parameter int FREQ_BASE = 4,
    parameter int VOL_BASE  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [PORT_W-1:0]            wr_port,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [CH_N-1:0][CNT_W-1:0]   period,
    output logic [CH_N-1:0][VOL_W-1:0]   loud
);
    for (genvar i = 0; i < CH_N; i++) begin : g_ch
        localparam int FP  = FREQ_BASE + i;
        localparam int VP  = VOL_BASE + i / 2;
        localparam int LSB = (i % 2 == 0) ? VOL_W : 0;

        logic [CNT_W-1:0] period_q;
        logic [VOL_W-1:0] loud_q;

        // Capture this channel's period word on a write to its port.
        always_ff @(posedge clk) begin
            if (!rst_n)
                period_q <= '0;
            else if (wr_en && wr_port == PORT_W'(FP))
                period_q <= wr_data[CNT_W-1:0];
        end

        // Capture this channel's loudness nibble from its shared port.
        always_ff @(posedge clk) begin
            if (!rst_n)
                loud_q <= '0;
            else if (wr_en && wr_port == PORT_W'(VP))
                loud_q <= wr_data[LSB +: VOL_W];
        end

        assign period[i] = period_q;
        assign loud[i]   = loud_q;
    end
endmodule

// File: rtl/tone_channel.sv
// One square-wave channel. On each tick the counter reloads at zero,
// otherwise counts down. The level inverts on the step from 1 to 0.
// A zero period parks the level high with the counter at zero.
// Assumes tick is a single-cycle enable.
module tone_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             level
);
    logic [CNT_W-1:0] cnt_q;
    logic             lvl_q;

    // Advance the counter and the level once per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lvl_q <= 1'b1;
        end else if (tick) begin
            if (period == '0) begin
                cnt_q <= '0;
                lvl_q <= 1'b1;
            end else if (cnt_q == '0) begin
                cnt_q <= period;
            end else begin
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1))
                    lvl_q <= ~lvl_q;
            end
        end
    end

    assign count = cnt_q;
    assign level = lvl_q;
endmodule

// File: rtl/tone_mix.sv
// Mixer: adds the loudness of every channel whose level is high.
// The sum width must hold CH_N full-scale loudness values.
module tone_mix #(
    parameter int CH_N  = 4,
    parameter int VOL_W = 4,
    parameter int SUM_W = 6
) (
    input  logic [CH_N-1:0]            level,
    input  logic [CH_N-1:0][VOL_W-1:0] loud,
    output logic [SUM_W-1:0]           sample
);
    // Gate each loudness by its level and accumulate.
    always_comb begin
        sample = '0;
        for (int i = 0; i < CH_N; i++) begin
            if (level[i])
                sample = sample + SUM_W'(loud[i]);
        end
    end
endmodule

// File: rtl/tone_mixer4.sv
// Top of the four-channel tone generator: port decode, per-channel
// counters and the mixer. All state resets synchronously on low rst_n.
module tone_mixer4
    import tone_pkg::*;
#(
    parameter int CH_N      = TONE_CH_N,
    parameter int CNT_W     = TONE_CNT_W,
    parameter int VOL_W     = TONE_VOL_W,
    parameter int PORT_W    = TONE_PORT_W,
    parameter int DATA_W    = TONE_DATA_W,
    parameter int FREQ_BASE = TONE_FREQ_P0,
    parameter int VOL_BASE  = TONE_VOL_P0,
    localparam int SUM_W    = VOL_W + $clog2(CH_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_port,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CH_N-1:0]   level,
    output logic [SUM_W-1:0]  sample
);
    logic [CH_N-1:0][CNT_W-1:0] period;
    logic [CH_N-1:0][VOL_W-1:0] loud;
    logic [CH_N-1:0][CNT_W-1:0] count;

    tone_regs #(
        .CH_N(CH_N), .CNT_W(CNT_W), .VOL_W(VOL_W), .PORT_W(PORT_W),
        .DATA_W(DATA_W), .FREQ_BASE(FREQ_BASE), .VOL_BASE(VOL_BASE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_port(wr_port),
        .wr_data(wr_data), .period(period), .loud(loud)
    );

    for (genvar i = 0; i < CH_N; i++) begin : g_chan
        tone_channel #(.CNT_W(CNT_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .tick(tick), .period(period[i]),
            .count(count[i]), .level(level[i])
        );
    end

    tone_mix #(.CH_N(CH_N), .VOL_W(VOL_W), .SUM_W(SUM_W)) u_mix (
        .level(level), .loud(loud), .sample(sample)
    );
endmodule

// File: rtl/tone_mixer4_chk.sv
// Checker for tone_mixer4, bound to every instance. Observes ports plus the
// period, loudness and counter buses between the submodules.
module tone_mixer4_chk #(
    parameter int CH_N  = 4,
    parameter int CNT_W = 16,
    parameter int VOL_W = 4,
    parameter int SUM_W = 6
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       tick,
    input logic [CH_N-1:0]            level,
    input logic [SUM_W-1:0]           sample,
    input logic [CH_N-1:0][CNT_W-1:0] period,
    input logic [CH_N-1:0][VOL_W-1:0] loud,
    input logic [CH_N-1:0][CNT_W-1:0] count
);
    function automatic logic [SUM_W-1:0] full_mix(input logic [CH_N-1:0][VOL_W-1:0] v);
        logic [SUM_W-1:0] s;
        s = '0;
        for (int i = 0; i < CH_N; i++) s = s + SUM_W'(v[i]);
        return s;
    endfunction

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (level == '1 && sample == '0));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(level) && $stable(count)));

    // R9
    all_high_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level == '1 |-> sample == full_mix(loud));

    // R9
    all_low_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level == '0 |-> sample == '0);

    for (genvar i = 0; i < CH_N; i++) begin : g_chk
        // R6
        reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && period[i] != '0 && count[i] == '0) |=> count[i] == $past(period[i]));

        // R7
        flip_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (level[i] != $past(level[i])) |-> count[i] == '0);

        // R8
        park_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && period[i] == '0) |=> (level[i] && count[i] == '0));
    end
endmodule

bind tone_mixer4 tone_mixer4_chk #(
    .CH_N(CH_N), .CNT_W(CNT_W), .VOL_W(VOL_W), .SUM_W(SUM_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .level(level), .sample(sample),
    .period(period), .loud(loud), .count(count)
);

// File: tb/sim_tone_mixer4.sv
module sim_tone_mixer4;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_port = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  level;
    logic [5:0]  sample;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural reference state
    int m_per [4];
    int m_cnt [4];
    int m_vol [4];
    bit m_lvl [4];
    int tick_count = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tone_mixer4 u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_port(wr_port), .wr_data(wr_data), .level(level), .sample(sample)
    );

    // Reference model: ticks act on old period words, then writes land (R10).
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_per[i] = 0; m_cnt[i] = 0; m_vol[i] = 0; m_lvl[i] = 1;
            end
        end else begin
            if (tick) begin
                tick_count++;
                for (int i = 0; i < 4; i++) begin
                    if (m_per[i] == 0) begin
                        m_cnt[i] = 0; m_lvl[i] = 1;
                    end else if (m_cnt[i] == 0) begin
                        m_cnt[i] = m_per[i];
                    end else begin
                        if (m_cnt[i] == 1) m_lvl[i] = !m_lvl[i];
                        m_cnt[i]--;
                    end
                end
            end
            if (wr_en) begin
                if (wr_port >= 4 && wr_port <= 7) m_per[wr_port-4] = int'(wr_data);
                else if (wr_port == 8) begin
                    m_vol[0] = int'(wr_data[7:4]); m_vol[1] = int'(wr_data[3:0]);
                end else if (wr_port == 9) begin
                    m_vol[2] = int'(wr_data[7:4]); m_vol[3] = int'(wr_data[3:0]);
                end
            end
        end
    end

    function automatic logic [3:0] exp_level();
        logic [3:0] l;
        for (int i = 0; i < 4; i++) l[i] = m_lvl[i];
        return l;
    endfunction

    function automatic int exp_sample();
        int s = 0;
        for (int i = 0; i < 4; i++) if (m_lvl[i]) s += m_vol[i];
        return s;
    endfunction

    // Compare against the model every cycle, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (level !== exp_level()) begin
                errors++;
                $display("FAIL R2 R6 R7 R8 level: actual %h expected %h", level, exp_level());
            end
            checks++;
            if (int'(sample) != exp_sample()) begin
                errors++;
                $display("FAIL R9 sample: actual %0d expected %0d", sample, exp_sample());
            end
        end
    end

    task automatic check(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic port_write(input logic [3:0] p, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_port = p; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Run ticks every 'gap' cycles and check toggle spacing per channel (R7).
    task automatic measure(input int cycles, input int gap, input int per [4]);
        logic [3:0] prev;
        int last [4];
        int ntog [4];
        for (int i = 0; i < 4; i++) begin last[i] = 0; ntog[i] = 0; end
        @(negedge clk);
        prev = level;
        for (int c = 0; c < cycles; c++) begin
            tick = (c % gap == 0);
            @(negedge clk);
            for (int i = 0; i < 4; i++) begin
                if (level[i] != prev[i]) begin
                    if (ntog[i] > 0) check("R7 half-period ticks", tick_count - last[i], per[i] + 1);
                    ntog[i]++;
                    last[i] = tick_count;
                end
            end
            prev = level;
        end
        tick = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (per[i] == 0) begin
                check("R8 no toggles with zero period", ntog[i], 0);
                check("R8 parked high", int'(level[i]), 1);
            end else begin
                check("R7 enough toggles seen", int'(ntog[i] >= 3), 1);
            end
        end
    endtask

    initial begin
        int per1 [4];
        int per2 [4];
        logic [3:0] snap;
        repeat (3) @(negedge clk);
        check("R1 level in reset", int'(level), 15);
        check("R1 sample in reset", int'(sample), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 level after reset", int'(level), 15);

        // R3: loudness fields, upper byte ignored
        port_write(4'h8, 16'hFF5C);
        port_write(4'h9, 16'h3A97);
        check("R3 R9 mix of all loudness", int'(sample), 5 + 12 + 9 + 7);

        // R4: unmapped ports do nothing
        port_write(4'h2, 16'h0001);
        port_write(4'hB, 16'h00FF);
        port_write(4'hF, 16'h1234);
        check("R4 sample unchanged", int'(sample), 33);
        repeat (10) begin @(negedge clk); tick = 1'b1; end
        @(negedge clk); tick = 1'b0;
        check("R4 R8 levels parked high", int'(level), 15);

        // R2: period words per channel; B stays zero
        port_write(4'h4, 16'd3);
        port_write(4'h6, 16'd7);
        port_write(4'h7, 16'd1);

        // R5: no tick, nothing moves
        snap = level;
        repeat (10) @(negedge clk);
        check("R5 level stable without tick", int'(level), int'(snap));

        per1 = '{3, 0, 7, 1};
        measure(200, 1, per1);

        // R10: write and tick in the same cycle; model covers the ordering
        @(negedge clk);
        wr_en = 1'b1; wr_port = 4'h4; wr_data = 16'd2; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        per2 = '{2, 0, 7, 1};
        measure(300, 3, per2);

        // R6 R8: zero a running channel, it parks high on next tick
        port_write(4'h6, 16'd0);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        check("R8 channel 2 parked after zeroing", int'(level[2]), 1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule